// File: doc/BRIEF.md
# Serial DAC Input Control Logic

This block is the digital front end of a 16-bit voltage-output converter. A host writes 24-bit frames over a three-wire serial link made of an active-low frame strobe, a serial clock and a data line. The block brings the three lines into its own clock domain and assembles each frame. It then decides whether the frame commits, aborts or resets the block.

It holds a 16-bit code register and a 2-bit power-down mode register. From these it drives the converter core and the output stage. The core is segmented: the upper code bits become a thermometer of segment enables, and the lower bits drive the binary ladder switches directly. The output stage gets a one-hot selection among normal drive, three-state, a weak pull-down and a strong pull-down. The analog parts are outside this block; only their digital controls leave it.

A frame takes effect only when its 24th bit arrives. Raising the strobe earlier abandons the frame. The exception is a frame that begins with a one bit, which is a software-reset candidate: it always runs to its 24th bit, and a frame of all ones returns the block to its power-on state.

Top module: `dac_frontend`

## Requirements
- R1: After reset the code register holds 0x8000 and the mode is 00 (normal), so out_sel is 4'b0001.
- R2: A falling edge of fsync_n starts a frame. Bits are taken MSB first from sdi at each falling edge of sclk while the frame is open.
- R3: At exactly the 24th falling sclk edge the frame is applied. Frame bits 23..18 must be zero, bits 17..16 are the mode, and bits 15..0 are the code. A mode 00 frame loads the code.
- R4: If fsync_n rises before the 24th falling edge of a frame whose first bit is 0, the frame is discarded: neither the code nor the mode changes.
- R5: After a frame completes, further sclk edges are ignored until fsync_n has gone high and then low again.
- R6: out_sel is one-hot with out_sel[m] set for mode m. Bit 0 is normal drive, bit 1 is three-state, bit 2 is the 100 kΩ pull-down and bit 3 is the 1 kΩ pull-down.
- R7: A frame with a nonzero mode changes the mode and leaves the code register unchanged; its data field is ignored.
- R8: A completed frame of all ones (0xFFFFFF) sets the code to 0x8000 and the mode to 00, the same as reset.
- R9: A frame whose first bit is 1 ignores fsync_n rising and completes at its 24th falling sclk edge.
- R10: A completed frame with a nonzero value in bits 23..18 that is not all ones changes nothing.
- R11: seg_en[i] is 1 exactly when code[15:12] > i, for i = 0..14. ladder_sw equals code[11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| fsync_n | input | 1 | Active-low frame strobe |
| sdi | input | 1 | Serial data, MSB first |
| dac_code | output | 16 | Current code register |
| pd_mode | output | 2 | Current power-down mode |
| seg_en | output | 15 | Thermometer enables for the upper segments |
| ladder_sw | output | 12 | Binary ladder switch controls |
| out_sel | output | 4 | One-hot output-stage selection |

## Verification
The bench builds the block with its default parameters: a 16-bit code, four segment bits, 2-bit mode and two synchronizer stages. The serial clock runs at eight system clocks per bit. With these values all sixteen segment patterns can be reached, and every mode code can be set. Aborts can be placed at the first bit and at the 23rd, and trailing clocks can follow a completed frame. A software-reset frame can have its strobe raised halfway through.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_HOLD  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/dacfe_in_sync.sv
module dacfe_in_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dacfe_frame_rx.sv
module dacfe_frame_rx
  import dacfe_pkg::*;
#(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_q,
  input  logic               fs_n_q,
  input  logic               sdi_q,
  output logic               frm_vld,
  output logic [FRAME_W-1:0] frm_word
);
  localparam int                CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(FRAME_W - 1);

  rx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] shreg;
  logic               lock;
  logic               sclk_d, fs_n_d;
  logic               sclk_fall, fs_fall;

  assign sclk_fall = sclk_d & ~sclk_q;
  assign fs_fall   = fs_n_d & ~fs_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b1;
      fs_n_d <= 1'b1;
    end else begin
      sclk_d <= sclk_q;
      fs_n_d <= fs_n_q;
    end
  end

  // R2 R4 R5 R9: frame sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      lock     <= 1'b0;
      frm_vld  <= 1'b0;
      frm_word <= '0;
    end else begin
      frm_vld <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (fs_fall) begin
            state <= RX_SHIFT;
            cnt   <= '0;
            shreg <= '0;
            lock  <= 1'b0;
          end
        end
        RX_SHIFT: begin
          if (fs_n_q && !lock) begin
            state <= RX_IDLE;
            cnt   <= '0;
            shreg <= '0;
          end else if (sclk_fall) begin
            shreg <= {shreg[FRAME_W-2:0], sdi_q};
            if (cnt == '0 && sdi_q) lock <= 1'b1;
            if (cnt == LAST) begin
              frm_vld  <= 1'b1;
              frm_word <= {shreg[FRAME_W-2:0], sdi_q};
              state    <= RX_HOLD;
              cnt      <= '0;
              lock     <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_HOLD: begin
          if (fs_n_q) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dacfe_seg_decode.sv
module dacfe_seg_decode #(
  parameter int SEG_BITS = 4,
  parameter int LADDER_W = 12,
  parameter int MODE_W   = 2
) (
  input  logic [SEG_BITS+LADDER_W-1:0]  code,
  input  logic [MODE_W-1:0]             mode,
  output logic [(1<<SEG_BITS)-2:0]      seg_en,
  output logic [LADDER_W-1:0]           ladder,
  output logic [(1<<MODE_W)-1:0]        sel
);
  localparam int SEG_N = (1 << SEG_BITS) - 1;
  localparam int SEL_N = 1 << MODE_W;

  logic [SEG_BITS-1:0] msb;
  assign msb    = code[SEG_BITS+LADDER_W-1 -: SEG_BITS];
  assign ladder = code[LADDER_W-1:0];

  // R11: thermometer segments
  for (genvar g = 0; g < SEG_N; g++) begin : g_seg
    assign seg_en[g] = (msb > SEG_BITS'(g));
  end

  // R6: one-hot output stage selection
  for (genvar m = 0; m < SEL_N; m++) begin : g_sel
    assign sel[m] = (mode == MODE_W'(m));
  end
endmodule

// File: rtl/dac_frontend.sv
module dac_frontend #(
  parameter int CODE_W      = 16,
  parameter int SEG_BITS    = 4,
  parameter int MODE_W      = 2,
  parameter int PAD_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sclk,
  input  logic                           fsync_n,
  input  logic                           sdi,
  output logic [CODE_W-1:0]              dac_code,
  output logic [MODE_W-1:0]              pd_mode,
  output logic [(1<<SEG_BITS)-2:0]       seg_en,
  output logic [CODE_W-SEG_BITS-1:0]     ladder_sw,
  output logic [(1<<MODE_W)-1:0]         out_sel
);
  localparam int FRAME_W  = PAD_W + MODE_W + CODE_W;
  localparam int LADDER_W = CODE_W - SEG_BITS;
  localparam int SEG_N    = (1 << SEG_BITS) - 1;
  localparam int SEL_N    = 1 << MODE_W;
  localparam logic [CODE_W-1:0] MID     = CODE_W'(1) << (CODE_W - 1);
  localparam int                MID_SEG = 1 << (SEG_BITS - 1);
  localparam logic [SEG_N-1:0]  SEG_RST = SEG_N'((64'd1 << MID_SEG) - 64'd1);

  logic [2:0] sync_q;
  dacfe_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({sdi, fsync_n, sclk}),
    .q   (sync_q)
  );

  logic               frm_vld;
  logic [FRAME_W-1:0] frm_word;
  dacfe_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .sclk_q   (sync_q[0]),
    .fs_n_q   (sync_q[1]),
    .sdi_q    (sync_q[2]),
    .frm_vld  (frm_vld),
    .frm_word (frm_word)
  );

  logic [PAD_W-1:0]  f_pad;
  logic [MODE_W-1:0] f_mode;
  logic [CODE_W-1:0] f_code;
  logic              is_swr, pad_ok;
  assign f_pad  = frm_word[FRAME_W-1 -: PAD_W];
  assign f_mode = frm_word[CODE_W +: MODE_W];
  assign f_code = frm_word[CODE_W-1:0];
  assign is_swr = &frm_word;
  assign pad_ok = (f_pad == '0);

  logic [CODE_W-1:0] code_q;
  logic [MODE_W-1:0] mode_q;

  // R1 R3 R7 R8 R10: commit rules
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= MID;
      mode_q <= '0;
    end else if (frm_vld) begin
      if (is_swr) begin
        code_q <= MID;
        mode_q <= '0;
      end else if (pad_ok) begin
        mode_q <= f_mode;
        if (f_mode == '0) code_q <= f_code;
      end
    end
  end

  logic [SEG_N-1:0]    seg_d;
  logic [LADDER_W-1:0] lad_d;
  logic [SEL_N-1:0]    sel_d;
  dacfe_seg_decode #(.SEG_BITS(SEG_BITS), .LADDER_W(LADDER_W), .MODE_W(MODE_W)) u_dec (
    .code   (code_q),
    .mode   (mode_q),
    .seg_en (seg_d),
    .ladder (lad_d),
    .sel    (sel_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_en    <= SEG_RST;
      ladder_sw <= '0;
      out_sel   <= SEL_N'(1);
    end else begin
      seg_en    <= seg_d;
      ladder_sw <= lad_d;
      out_sel   <= sel_d;
    end
  end

  assign dac_code = code_q;
  assign pd_mode  = mode_q;
endmodule

// File: rtl/dac_frontend_chk.sv
module dac_frontend_chk #(
  parameter int CODE_W  = 16,
  parameter int MODE_W  = 2,
  parameter int FRAME_W = 24,
  parameter int SEG_N   = 15,
  parameter int SEL_N   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               frm_vld,
  input logic [FRAME_W-1:0] frm_word,
  input logic [CODE_W-1:0]  code_q,
  input logic [MODE_W-1:0]  mode_q,
  input logic [SEG_N-1:0]   seg_en,
  input logic [SEL_N-1:0]   out_sel
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [SEG_N-1:0] seg_inc;
  logic             swr, pad_bad, pd_frame;
  assign seg_inc  = seg_en + 1'b1;
  assign swr      = &frm_word;
  assign pad_bad  = (frm_word[FRAME_W-1:CODE_W+MODE_W] != '0);
  assign pd_frame = (frm_word[CODE_W +: MODE_W] != '0);

  p_reset_mid_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_q == MID && mode_q == '0));

  p_no_frame_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !frm_vld |=> ($stable(code_q) && $stable(mode_q)));

  p_onehot_sel_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot(out_sel));

  p_pd_keeps_code_r7: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && !swr && pd_frame) |=> $stable(code_q));

  p_swreset_r8: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && swr) |=> (code_q == MID && mode_q == '0));

  p_bad_pad_r10: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && !swr && pad_bad) |=> ($stable(code_q) && $stable(mode_q)));

  p_thermo_r11: assert property (@(posedge clk) disable iff (rst)
    ((seg_inc & seg_en) == '0));
endmodule

bind dac_frontend dac_frontend_chk #(
  .CODE_W(CODE_W), .MODE_W(MODE_W), .FRAME_W(FRAME_W), .SEG_N(SEG_N), .SEL_N(SEL_N)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .frm_vld  (frm_vld),
  .frm_word (frm_word),
  .code_q   (code_q),
  .mode_q   (mode_q),
  .seg_en   (seg_en),
  .out_sel  (out_sel)
);

// File: tb/tb_dac_frontend.sv
module tb_dac_frontend;
  localparam int H      = 4;
  localparam int SETTLE = 14;
  localparam int GAP    = 36;

  logic        clk = 1'b0;
  logic        rst;
  logic        sclk, fsync_n, sdi;
  logic [15:0] dac_code;
  logic [1:0]  pd_mode;
  logic [14:0] seg_en;
  logic [11:0] ladder_sw;
  logic [3:0]  out_sel;

  always #5 clk = ~clk;

  dac_frontend dut (
    .clk(clk), .rst(rst), .sclk(sclk), .fsync_n(fsync_n), .sdi(sdi),
    .dac_code(dac_code), .pd_mode(pd_mode), .seg_en(seg_en),
    .ladder_sw(ladder_sw), .out_sel(out_sel)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] q_code [$];
  logic [1:0]  q_mode [$];
  string       q_tag  [$];

  logic [15:0] m_code;
  logic [1:0]  m_mode;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input string tag);
    q_code.push_back(m_code);
    q_mode.push_back(m_mode);
    q_tag.push_back(tag);
  endtask

  // Driver: shifts a frame and updates the expectation model
  task automatic send(input logic [23:0] w, input int nbits, input int rise_after, input string tag);
    bit completes;
    fsync_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i == rise_after) fsync_n = 1'b1;
      sdi = (i < 24) ? w[23-i] : 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      repeat (H) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (H) @(negedge clk);
    fsync_n = 1'b1;
    completes = (nbits >= 24) && ((rise_after >= 24) || (w[23] && rise_after >= 1));
    if (completes) begin
      if (w == 24'hFFFFFF) begin
        m_code = 16'h8000;
        m_mode = 2'b00;
      end else if (w[23:18] == 6'd0) begin
        m_mode = w[17:16];
        if (w[17:16] == 2'b00) m_code = w[15:0];
      end
    end
    push(tag);
    repeat (GAP) @(negedge clk);
  endtask

  // Monitor: compares results against queued expectations
  initial begin
    forever begin
      wait (q_code.size() > 0);
      repeat (SETTLE) @(negedge clk);
      begin
        logic [15:0] ec;
        logic [1:0]  em;
        string       t;
        logic [14:0] es;
        ec = q_code.pop_front();
        em = q_mode.pop_front();
        t  = q_tag.pop_front();
        for (int i = 0; i < 15; i++) es[i] = (int'(ec[15:12]) > i);
        chk(t, "dac_code", dac_code, ec);
        chk(t, "pd_mode", pd_mode, em);
        chk({t, " R11"}, "seg_en", seg_en, es);
        chk({t, " R11"}, "ladder_sw", ladder_sw, ec[11:0]);
        chk({t, " R6"}, "out_sel", out_sel, 4'b0001 << em);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sclk = 1'b1; fsync_n = 1'b1; sdi = 1'b0;
    m_code = 16'h8000; m_mode = 2'b00;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    push("R1 reset");
    repeat (GAP) @(negedge clk);

    send(24'h001234, 24, 99, "R2 R3 load");
    send(24'h00FFFF, 24, 99, "R3 R11 full");
    send(24'h000000, 24, 99, "R3 R11 zero");
    send(24'h00A5C3, 24, 99, "R2 msb-first");
    send(24'h00ABCD, 10, 99, "R4 abort early");
    send(24'h007777, 23, 99, "R4 abort at 23");
    send(24'h004321, 32, 99, "R5 trailing clocks");
    send(24'h01BEEF, 24, 99, "R7 R6 three-state");
    send(24'h020000, 24, 99, "R7 R6 100k");
    send(24'h03F00F, 24, 99, "R7 R6 1k");
    send(24'h00E001, 24, 99, "R3 wake");
    send(24'h040001, 24, 99, "R10 bad pad");
    send(24'h801111, 24, 99, "R10 R9 lead one");
    send(24'h025555, 24, 99, "R7 before reset");
    send(24'hFFFFFF, 24, 99, "R8 swreset");
    send(24'h003C3C, 24, 99, "R3 reload");
    send(24'hFFFFFF, 24, 12, "R9 R8 no abort");

    wait (q_code.size() == 0);
    repeat (SETTLE + 4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule